// File: doc/BRIEF.md
# Serial frame receiver

This block sits behind the word aligner and decoder of a serial front-panel data link. Each cycle it may receive one link word. A select flag marks the word as either a payload word or a control code. The receiver follows the framing carried by the control codes and forwards every payload word that arrives inside a frame to a receive FIFO write port. When a SYNC frame closes, it writes a SYNC marker entry. It tracks two frame types. A normal frame closes with no marker. A SYNC frame is announced by a sync-with-data code placed before its start-of-frame.

The remote end's sideband levels are not sent as separate bits. They are rebuilt from which start-of-frame or status end-of-frame variant arrives. Those are the three parallel-port levels (pio1, pio2, direction) and the remote not-ready and overflow flags. The receiver holds each rebuilt level until another variant replaces it. STOP and GO codes drive a remote-stopped level, which the local transmitter uses to hold off data. Framing violations produce a one-cycle protocol-error pulse.

Control codes are taken from word bits [4:0], and the upper bits of a control word are ignored. With the default `OUT_REG = 1`, every output reflects the word sampled at the previous rising edge.

Top module: `sfr_frame_rx`

## Requirements
- R1: While reset is asserted and after its release, with no word received, wr_en, wr_sync, wr_data, proto_err, pio1, pio2, dir, rmt_ovf, rmt_nrdy and rmt_stopped are all 0.
- R2: A start-of-frame code 0x08..0x0F sets {pio1,pio2,dir} to code bits [2:0] (bit 2 = pio1, bit 0 = dir) one cycle later. These levels hold until the next start-of-frame.
- R3: A status end-of-frame code 0x10..0x13 sets {rmt_ovf,rmt_nrdy} to code bits [1:0] (bit 1 = overflow). It closes any open frame without a marker and without an error.
- R4: A payload word (in_ctrl = 0) received inside an open frame gives wr_en = 1, wr_sync = 0 and wr_data equal to the word one cycle later.
- R5: A mark end-of-frame code 0x14 in an open frame gives a marker write one cycle later (wr_en = 1, wr_sync = 1, wr_data = 0) and closes the frame. A frame end-of-frame code 0x15 closes a normal frame with no write.
- R6: A sync-with-data code 0x16 makes the next start-of-frame open a SYNC frame. Its payload words are written before its closing marker. A 0x15 code closing a SYNC frame raises proto_err and writes no marker.
- R7: STOP (0x17) sets and GO (0x18) clears rmt_stopped one cycle later, in any framing state, without changing the framing state.
- R8: An IDLE code 0x00, or a cycle with in_valid = 0, changes no output and no framing state.
- R9: A payload word received with no frame open raises proto_err for one cycle and is not written.
- R10: A 0x14 or 0x15 code with no frame open raises proto_err and writes nothing.
- R11: A start-of-frame received inside an open frame raises proto_err, closes the old frame without a marker and opens the new one.
- R12: Any other control code (0x01..0x07, 0x19..0x1F) raises proto_err and changes no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A link word is present this cycle |
| in_ctrl | input | 1 | 1: the word is a control code in bits [4:0]; 0: the word is payload |
| in_word | input | DATA_W | Link word |
| wr_en | output | 1 | Receive FIFO write strobe |
| wr_sync | output | 1 | The write is a SYNC marker |
| wr_data | output | DATA_W | Receive FIFO write data (0 for a marker) |
| proto_err | output | 1 | One-cycle framing violation pulse |
| pio1 | output | 1 | Rebuilt remote pio1 level |
| pio2 | output | 1 | Rebuilt remote pio2 level |
| dir | output | 1 | Rebuilt remote direction level |
| rmt_ovf | output | 1 | Rebuilt remote FIFO overflow flag |
| rmt_nrdy | output | 1 | Rebuilt remote not-ready flag |
| rmt_stopped | output | 1 | Remote asked the local transmitter to hold off |

## Verification
One start-of-frame that arrives inside an open frame does three jobs in the same cycle: it closes the old frame with an error, it opens the new frame (possibly as a SYNC frame), and it reloads the three sideband levels. Directed sequences provoke this both in normal and in SYNC frames. Random streams with a dense mix of start-of-frame codes provoke it often. A bench model judges, in the cycle after each word, the error pulse, the sideband value and whether the following payload word is written. STOP/GO codes are also placed inside open SYNC frames to show that they leave the frame and its closing marker intact.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam int CODE_W = 5;

   localparam logic [CODE_W-1:0] C_IDLE = 5'h00;
   localparam logic [CODE_W-1:0] C_MEOF = 5'h14;
   localparam logic [CODE_W-1:0] C_FEOF = 5'h15;
   localparam logic [CODE_W-1:0] C_SWDV = 5'h16;
   localparam logic [CODE_W-1:0] C_STOP = 5'h17;
   localparam logic [CODE_W-1:0] C_GO   = 5'h18;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_SYNCF = 2'd2
   } rx_state_e;

   typedef enum logic [3:0] {
      K_NONE, K_DATA, K_SOF, K_SEOF, K_MEOF, K_FEOF, K_SWDV, K_STOP, K_GO, K_BAD
   } word_kind_e;

   typedef struct packed {
      word_kind_e kind;
      logic [2:0] arg;
   } word_cls_t;
endpackage

// File: rtl/sfr_word_class.sv
module sfr_word_class
   import sfr_pkg::*;
(
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [CODE_W-1:0] in_code,
   output word_cls_t         cls
);
   always_comb begin
      cls.arg  = in_code[2:0];
      cls.kind = K_NONE;
      if (in_valid) begin
         if (!in_ctrl) begin
            cls.kind = K_DATA;
         end else if (in_code[4:3] == 2'b01) begin
            cls.kind = K_SOF;
         end else if (in_code[4:2] == 3'b100) begin
            cls.kind = K_SEOF;
         end else begin
            case (in_code)
               C_IDLE:  cls.kind = K_NONE;
               C_MEOF:  cls.kind = K_MEOF;
               C_FEOF:  cls.kind = K_FEOF;
               C_SWDV:  cls.kind = K_SWDV;
               C_STOP:  cls.kind = K_STOP;
               C_GO:    cls.kind = K_GO;
               default: cls.kind = K_BAD;
            endcase
         end
      end
   end
endmodule

// File: rtl/sfr_frame_fsm.sv
module sfr_frame_fsm
   import sfr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  word_cls_t         cls,
   input  logic [DATA_W-1:0] word,
   output logic              nx_we,
   output logic              nx_sync,
   output logic [DATA_W-1:0] nx_data,
   output logic              nx_err
);
   rx_state_e st_q, st_d;
   logic      pend_q, pend_d;

   always_comb begin
      st_d    = st_q;
      pend_d  = pend_q;
      nx_we   = 1'b0;
      nx_sync = 1'b0;
      nx_err  = 1'b0;
      case (cls.kind)
         K_DATA: begin
            if (st_q == ST_IDLE) nx_err = 1'b1;
            else                 nx_we  = 1'b1;
         end
         K_SOF: begin
            nx_err = (st_q != ST_IDLE);
            st_d   = pend_q ? ST_SYNCF : ST_FRAME;
            pend_d = 1'b0;
         end
         K_SEOF: st_d = ST_IDLE;
         K_MEOF: begin
            if (st_q == ST_IDLE) begin
               nx_err = 1'b1;
            end else begin
               nx_we   = 1'b1;
               nx_sync = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         K_FEOF: begin
            nx_err = (st_q != ST_FRAME);
            st_d   = ST_IDLE;
         end
         K_SWDV: pend_d = 1'b1;
         K_BAD:  nx_err = 1'b1;
         default: ;
      endcase
   end

   assign nx_data = nx_sync ? '0 : word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/sfr_sideband.sv
module sfr_sideband
   import sfr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  word_cls_t cls,
   output logic [2:0] lvl3,
   output logic [1:0] stat2,
   output logic       stopped
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl3    <= '0;
         stat2   <= '0;
         stopped <= 1'b0;
      end else begin
         if (cls.kind == K_SOF)  lvl3    <= cls.arg;
         if (cls.kind == K_SEOF) stat2   <= cls.arg[1:0];
         if (cls.kind == K_STOP) stopped <= 1'b1;
         if (cls.kind == K_GO)   stopped <= 1'b0;
      end
   end
endmodule

// File: rtl/sfr_frame_rx.sv
module sfr_frame_rx
   import sfr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [DATA_W-1:0] in_word,
   output logic              wr_en,
   output logic              wr_sync,
   output logic [DATA_W-1:0] wr_data,
   output logic              proto_err,
   output logic              pio1,
   output logic              pio2,
   output logic              dir,
   output logic              rmt_ovf,
   output logic              rmt_nrdy,
   output logic              rmt_stopped
);
   generate
      if (DATA_W < CODE_W) begin : g_bad_width
         $error("sfr_frame_rx: DATA_W must hold a control code");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
         $error("sfr_frame_rx: OUT_REG must be 0 or 1");
      end
   endgenerate

   word_cls_t         cls;
   logic              nx_we, nx_sync, nx_err;
   logic [DATA_W-1:0] nx_data;
   logic [2:0]        lvl3;
   logic [1:0]        stat2;

   sfr_word_class u_class (
      .in_valid (in_valid),
      .in_ctrl  (in_ctrl),
      .in_code  (in_word[CODE_W-1:0]),
      .cls      (cls)
   );

   sfr_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cls     (cls),
      .word    (in_word),
      .nx_we   (nx_we),
      .nx_sync (nx_sync),
      .nx_data (nx_data),
      .nx_err  (nx_err)
   );

   sfr_sideband u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .cls     (cls),
      .lvl3    (lvl3),
      .stat2   (stat2),
      .stopped (rmt_stopped)
   );

   assign {pio1, pio2, dir}   = lvl3;
   assign {rmt_ovf, rmt_nrdy} = stat2;

   generate
      if (OUT_REG != 0) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_en     <= 1'b0;
               wr_sync   <= 1'b0;
               wr_data   <= '0;
               proto_err <= 1'b0;
            end else begin
               wr_en     <= nx_we;
               wr_sync   <= nx_sync;
               wr_data   <= nx_we ? nx_data : '0;
               proto_err <= nx_err;
            end
         end
      end else begin : g_out_comb
         assign wr_en     = nx_we;
         assign wr_sync   = nx_sync;
         assign wr_data   = nx_we ? nx_data : '0;
         assign proto_err = nx_err;
      end
   endgenerate
endmodule

// File: rtl/sfr_frame_rx_chk.sv
module sfr_frame_rx_chk
   import sfr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int OUT_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ctrl,
   input logic [CODE_W-1:0] in_code,
   input logic              wr_en,
   input logic              wr_sync,
   input logic [DATA_W-1:0] wr_data,
   input logic              proto_err,
   input logic              pio1,
   input logic              pio2,
   input logic              dir,
   input logic              rmt_ovf,
   input logic              rmt_nrdy,
   input logic              rmt_stopped
);
   logic is_ctl, is_sof, is_seof;
   assign is_ctl  = in_valid && in_ctrl;
   assign is_sof  = is_ctl && (in_code[4:3] == 2'b01);
   assign is_seof = is_ctl && (in_code[4:2] == 3'b100);

   // R5
   marker_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sync |-> (wr_en && wr_data == '0));

   generate
      if (OUT_REG != 0) begin : g_seq
         // R7
         stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_ctl && in_code == C_STOP) |=> rmt_stopped);
         // R7
         go_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_ctl && in_code == C_GO) |=> !rmt_stopped);
         // R2
         sof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !is_sof |=> $stable({pio1, pio2, dir}));
         // R3
         seof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !is_seof |=> $stable({rmt_ovf, rmt_nrdy}));
         // R8
         idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_valid || (in_ctrl && in_code == C_IDLE)) |=> (!wr_en && !proto_err));
      end
   endgenerate
endmodule

bind sfr_frame_rx sfr_frame_rx_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ctrl     (in_ctrl),
   .in_code     (in_word[4:0]),
   .wr_en       (wr_en),
   .wr_sync     (wr_sync),
   .wr_data     (wr_data),
   .proto_err   (proto_err),
   .pio1        (pio1),
   .pio2        (pio2),
   .dir         (dir),
   .rmt_ovf     (rmt_ovf),
   .rmt_nrdy    (rmt_nrdy),
   .rmt_stopped (rmt_stopped)
);

// File: tb/sfr_frame_rx_bench.sv
module sfr_frame_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 32;
   localparam int N_RAND     = 4000;
   localparam int WDOG       = 50000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ctrl = 1'b0;
   logic [DW-1:0] in_word = '0;
   logic          wr_en, wr_sync, proto_err;
   logic [DW-1:0] wr_data;
   logic          pio1, pio2, dir, rmt_ovf, rmt_nrdy, rmt_stopped;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference model state: 0 idle, 1 normal frame, 2 sync frame
   int       m_st = 0;
   bit       m_pend = 1'b0;
   bit [2:0] m_lvl = '0;
   bit [1:0] m_stat = '0;
   bit       m_stop = 1'b0;
   bit       e_we, e_sync, e_err;
   bit [DW-1:0] e_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfr_frame_rx #(.DATA_W(DW)) u_sfr_frame_rx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
      .in_word(in_word), .wr_en(wr_en), .wr_sync(wr_sync), .wr_data(wr_data),
      .proto_err(proto_err), .pio1(pio1), .pio2(pio2), .dir(dir),
      .rmt_ovf(rmt_ovf), .rmt_nrdy(rmt_nrdy), .rmt_stopped(rmt_stopped)
   );

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // expected results of one link word, from the requirements
   task automatic model(input bit v, input bit c, input bit [DW-1:0] w);
      bit [4:0] k;
      k = w[4:0];
      e_we = 0; e_sync = 0; e_err = 0; e_data = '0;
      if (!v) return;
      if (!c) begin
         if (m_st == 0) e_err = 1;                   // R9
         else begin e_we = 1; e_data = w; end         // R4
      end else if (k >= 5'h08 && k <= 5'h0F) begin   // R2, R11
         e_err  = (m_st != 0);
         m_st   = m_pend ? 2 : 1;
         m_pend = 0;
         m_lvl  = k[2:0];
      end else if (k >= 5'h10 && k <= 5'h13) begin   // R3
         m_stat = k[1:0];
         m_st   = 0;
      end else if (k == 5'h14) begin                 // R5, R10
         if (m_st == 0) e_err = 1;
         else begin e_we = 1; e_sync = 1; m_st = 0; end
      end else if (k == 5'h15) begin                 // R5, R6, R10
         e_err = (m_st != 1);
         m_st  = 0;
      end else if (k == 5'h16) m_pend = 1;           // R6
      else if (k == 5'h17) m_stop = 1;               // R7
      else if (k == 5'h18) m_stop = 0;               // R7
      else if (k != 5'h00) e_err = 1;                // R12
   endtask

   task automatic step(input bit v, input bit c, input bit [DW-1:0] w, input string tag);
      @(negedge clk);
      in_valid = v; in_ctrl = c; in_word = w;
      model(v, c, w);
      @(posedge clk);
      #1;
      check(tag, "wr_en", wr_en, e_we);
      check(tag, "wr_sync", wr_sync, e_sync);
      if (e_we) check(tag, "wr_data", wr_data, e_data);
      check(tag, "proto_err", proto_err, e_err);
      check(tag, "pio1/pio2/dir", {pio1, pio2, dir}, m_lvl);
      check(tag, "ovf/nrdy", {rmt_ovf, rmt_nrdy}, m_stat);
      check(tag, "rmt_stopped", rmt_stopped, m_stop);
   endtask

   task automatic ctl(input bit [4:0] k, input string tag);
      step(1, 1, {$urandom, 5'h00} | DW'(k), tag);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5f3a_91c4));
      repeat (3) @(posedge clk);
      #1;
      // R1 during reset
      check("R1", "wr_en", wr_en, 0);
      check("R1", "proto_err", proto_err, 0);
      check("R1", "sideband", {pio1, pio2, dir, rmt_ovf, rmt_nrdy, rmt_stopped}, 0);
      @(negedge clk); rst_n = 1'b1;
      step(0, 0, '0, "R1");

      // directed corner cases
      ctl(5'h0D, "R2");                     // pio1=1 pio2=0 dir=1
      step(1, 0, 32'hCAFE_0001, "R4");
      ctl(5'h0A, "R11");                    // SOF inside open frame
      step(1, 0, 32'hCAFE_0002, "R11");     // new frame is open
      ctl(5'h14, "R5");                     // marker
      step(1, 0, 32'h1234_5678, "R9");      // data with no frame
      ctl(5'h15, "R10");
      ctl(5'h14, "R10");
      ctl(5'h0B, "R5");
      step(1, 0, 32'h0000_0055, "R4");
      ctl(5'h15, "R5");                     // normal close, no write
      ctl(5'h16, "R6");
      ctl(5'h0F, "R6");                     // opens sync frame
      step(1, 0, 32'hABCD_0001, "R6");
      ctl(5'h17, "R7");                     // STOP inside sync frame
      step(1, 0, 32'hABCD_0002, "R7");
      ctl(5'h14, "R6");                     // marker still written
      ctl(5'h18, "R7");
      ctl(5'h16, "R6");
      ctl(5'h08, "R6");
      ctl(5'h15, "R6");                     // wrong EOF for sync frame
      ctl(5'h09, "R3");
      ctl(5'h12, "R3");                     // ovf=1 nrdy=0, closes frame
      step(1, 0, 32'h77, "R3");             // frame closed: error
      ctl(5'h03, "R12");
      ctl(5'h1E, "R12");
      ctl(5'h00, "R8");
      step(0, 1, 32'h14, "R8");             // not valid
      ctl(5'h16, "R11");
      ctl(5'h0C, "R11");
      ctl(5'h0E, "R11");                    // SOF in sync frame
      step(1, 0, 32'h99, "R11");
      ctl(5'h13, "R3");

      // constrained random streams
      for (int i = 0; i < N_RAND; i++) begin
         int r;
         r = $urandom % 100;
         if (r < 8)       step(0, $urandom, $urandom, "R8");
         else if (r < 38) step(1, 0, $urandom, "R4");
         else if (r < 50) ctl(5'h08 + 5'($urandom % 8), "R2");
         else if (r < 57) ctl(5'h10 + 5'($urandom % 4), "R3");
         else if (r < 65) ctl(5'h14, "R5");
         else if (r < 71) ctl(5'h15, "R5");
         else if (r < 77) ctl(5'h16, "R6");
         else if (r < 82) ctl(5'h17, "R7");
         else if (r < 87) ctl(5'h18, "R7");
         else if (r < 93) ctl(5'h00, "R8");
         else if ($urandom % 2) ctl(5'h01 + 5'($urandom % 7), "R12");
         else ctl(5'h19 + 5'($urandom % 7), "R12");
      end
      summary();
      $finish;
   end
endmodule